// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns write requests from a synchronous clock domain into correctly timed write cycles on an external asynchronous static RAM. A request carries an address and a data word and is taken over a valid/ready handshake. The block then moves the memory's address bus, data bus, data driver enable, write strobe and read enable through three timed phases. First the address settles with the strobe inactive. Then the strobe is held active with data on the bus. Finally address and data are held after the strobe releases. Each phase length is a parameter counted in whole clock cycles.

A streaming mode writes consecutive words without releasing the strobe. Each step advances a binary counter, and the address bus carries the Gray code of that counter, so exactly one address line toggles per word. Every address change closes the write of the previous word. The data word is launched on the falling clock edge, so it follows its address by half a clock period. A burst ends on the word marked last. That word gets a full strobe period, then the strobe releases and the hold phase runs before the bus is freed.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, req_ready_o is 1, sram_we_n_o is 1, sram_data_oe_o is 0 and sram_oe_n_o is 1.
- R2: An accepted request puts its address on sram_addr_o with sram_we_n_o high for exactly SETUP_CYC cycles before the strobe falls. The address does not change on the edge where the strobe falls.
- R3: The final strobe-low segment of every write lasts exactly max(DSETUP_CYC, PULSE_CYC) cycles. For a single write this is the whole low period. For a burst it runs from the last word's address change to the strobe's rise.
- R4: When the strobe rises, the address stays unchanged on that edge and for the whole hold phase. The data drivers stay enabled for exactly HOLD_CYC cycles after the rise and then turn off.
- R5: req_ready_o is 0 during the address-setup, strobe and hold phases. It is 1 in idle and in the word slots of a streaming burst.
- R6: sram_oe_n_o stays 1 at all times.
- R7: sram_data_oe_o is 1 whenever sram_we_n_o is 0 and during the hold phase. It is 0 in idle and during address setup.
- R8: With req_stream_i=0, the address bus carries req_addr_i unchanged and req_last_i has no effect. The memory ends up holding req_data_i at that address.
- R9: With req_stream_i=1, word i of a burst is written at the Gray code (b ^ (b>>1)) of b = req_addr_i of the first word plus i, modulo 2^AW. The strobe stays low between words, and each address step changes exactly one bit.
- R10: sram_data_o changes only on falling clock edges. A new word's data appears half a period after its address.
- R11: A streaming request with req_last_i=1 closes the burst: that word is written and the hold phase follows. A first streaming request with req_last_i=1 is a one-word burst at the Gray-coded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on this edge when high with valid |
| req_addr_i | input | AW | Write address; burst base on a burst's first word |
| req_data_i | input | DW | Write data |
| req_stream_i | input | 1 | First word selects streaming mode |
| req_last_i | input | 1 | Marks the last word of a burst |
| sram_addr_o | output | AW | Memory address bus |
| sram_data_o | output | DW | Memory data bus value |
| sram_data_oe_o | output | 1 | Data bus driver enable |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Memory read enable, active low, held inactive |

## Verification
On the edge that accepts a request, the address moves at once. The strobe falls SETUP_CYC edges later and rises max(DSETUP_CYC, PULSE_CYC) edges after that. The drivers turn off HOLD_CYC edges after the rise, and ready returns on that same edge. Data moves half a period after the edge that accepted it. The bench samples each clock cycle twice: a quarter period after the rising edge, and a quarter period before the next one. It measures each phase by counting samples between the strobe and address events. It checks that data seen at the early sample equals data seen at the previous late sample, which proves the launch happens on the falling edge. A behavioural memory in the bench records each write when the strobe rises or the address moves under a low strobe. At the end its contents are compared with the contents predicted from the issued requests.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_STREAM,
    ST_HOLD
  } sws_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sws_phase_timer.sv
module sws_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sws_addr_gen.sv
module sws_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          gray_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] bin_q, bin_d, gray_d, addr_q;
  logic          gray_q, gray_sel;

  assign bin_d    = load_i ? base_i : bin_q + AW'(1);
  assign gray_sel = load_i ? gray_i : gray_q;

  for (genvar i = 0; i < AW; i++) begin : g_gray
    if (i == AW - 1) begin : g_msb
      assign gray_d[i] = bin_d[i];
    end else begin : g_bit
      assign gray_d[i] = bin_d[i] ^ bin_d[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      addr_q <= '0;
      gray_q <= 1'b0;
    end else if (load_i || step_i) begin
      bin_q  <= bin_d;
      addr_q <= gray_sel ? gray_d : bin_d;
      gray_q <= gray_sel;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/sws_data_launch.sv
module sws_data_launch #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);

  logic [DW-1:0] stage_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q <= '0;
    else if (cap_i) stage_q <= data_i;
  end

  // launch half a cycle after the address edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= stage_q;
  end

  assign data_o = out_q;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sws_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 2,
  parameter int DSETUP_CYC = 3,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_stream_i,
  input  logic          req_last_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_data_o,
  output logic          sram_data_oe_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o
);

  localparam int SETUP_L = max2(SETUP_CYC, 1);
  localparam int PULSE_L = max2(max2(DSETUP_CYC, PULSE_CYC), 1);
  localparam int HOLD_L  = max2(HOLD_CYC, 1);
  localparam int LONGEST = max2(max2(SETUP_L, PULSE_L), HOLD_L);
  localparam int CW      = $clog2(LONGEST + 1);

  sws_state_e    state_q, state_d;
  logic          stream_q, stream_d;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          accept, addr_load, addr_step;

  always_comb begin
    state_d  = state_q;
    stream_d = stream_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CW'(SETUP_L - 1);
        stream_d = req_stream_i & ~req_last_i;
      end
      ST_SETUP: if (tmr_done) begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(PULSE_L - 1);
      end
      ST_PULSE: if (tmr_done) begin
        if (stream_q) begin
          state_d = ST_STREAM;
        end else begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CW'(HOLD_L - 1);
        end
      end
      // strobe held; each accepted word moves the address
      ST_STREAM: if (req_valid_i && req_last_i) begin
        state_d  = ST_PULSE;
        stream_d = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = CW'(PULSE_L - 1);
      end
      ST_HOLD: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      stream_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      stream_q <= stream_d;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_STREAM);
  assign accept      = req_valid_i && req_ready_o;
  assign addr_load   = req_valid_i && (state_q == ST_IDLE);
  assign addr_step   = req_valid_i && (state_q == ST_STREAM);

  sws_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sws_addr_gen #(.AW(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_load),
    .step_i (addr_step),
    .gray_i (req_stream_i),
    .base_i (req_addr_i),
    .addr_o (sram_addr_o)
  );

  sws_data_launch #(.DW(DW)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (accept),
    .data_i (req_data_i),
    .data_o (sram_data_o)
  );

  assign sram_we_n_o    = !((state_q == ST_PULSE) || (state_q == ST_STREAM));
  assign sram_data_oe_o = (state_q == ST_PULSE) || (state_q == ST_STREAM) ||
                          (state_q == ST_HOLD);
  assign sram_oe_n_o    = 1'b1;

endmodule

// File: rtl/sws_checks.sv
module sws_checks #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_i,
  input logic          we_n_i,
  input logic          data_oe_i,
  input logic          oe_n_i,
  input logic [AW-1:0] addr_i
);

  a_r6_oe_n_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i);

  a_r2_addr_stable_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_i) |-> $stable(addr_i));

  a_r4_addr_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_i) |-> $stable(addr_i));

  a_r9_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_i && !$past(we_n_i) && (addr_i != $past(addr_i)))
      |-> ($countones(addr_i ^ $past(addr_i)) == 1));

  a_r7_drivers_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> data_oe_i);

  a_r5_busy_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_n_i && data_oe_i) |-> !ready_i);

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && we_n_i) |-> !data_oe_i);

endmodule

bind sram_wr_seq sws_checks #(.AW(AW)) u_sws_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (req_ready_o),
  .we_n_i    (sram_we_n_o),
  .data_oe_i (sram_data_oe_o),
  .oe_n_i    (sram_oe_n_o),
  .addr_i    (sram_addr_o)
);

// File: tb/sim_sram_wr_seq.sv
`timescale 1ns/1ps
module sim_sram_wr_seq;

  localparam int  AW = 8;
  localparam int  DW = 16;
  localparam int  S  = 2;
  localparam int  DS = 3;
  localparam int  PW = 2;
  localparam int  H  = 2;
  localparam int  PL = (DS > PW) ? DS : PW;
  localparam real CLK_PERIOD = 10.0;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_stream = 1'b0;
  logic          req_last = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_data;
  logic          sram_data_oe, sram_we_n, sram_oe_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_mem [2**AW];
  logic [DW-1:0] mdl_mem [2**AW];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_wr_seq #(.AW(AW), .DW(DW), .SETUP_CYC(S), .DSETUP_CYC(DS),
                .PULSE_CYC(PW), .HOLD_CYC(H)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .req_stream_i(req_stream), .req_last_i(req_last),
    .sram_addr_o(sram_addr), .sram_data_o(sram_data),
    .sram_data_oe_o(sram_data_oe), .sram_we_n_o(sram_we_n),
    .sram_oe_n_o(sram_oe_n)
  );

  function automatic logic [AW-1:0] g_of(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // timing monitor and behavioural memory
  logic          p_we = 1'b1, p_doe = 1'b0, started = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_data = '0;
  int setup_cnt = 0, low_seg = 0, hold_cnt = 0;

  always @(posedge clk_i) begin
    #(CLK_PERIOD*0.25);
    if (rst_ni && started) check("R10 data held at rising edge", sram_data, p_data);
    #(CLK_PERIOD*0.5);
    if (rst_ni) begin
      if (sram_oe_n !== 1'b1) check("R6 read enable", sram_oe_n, 1);
      if (!sram_we_n && !sram_data_oe) check("R7 drivers with strobe", sram_data_oe, 1);
      if (sram_we_n && !sram_data_oe && !req_ready) setup_cnt++;
      if (p_we && !sram_we_n) begin
        check("R2 setup length", setup_cnt, S);
        check("R2 address at fall", sram_addr, p_addr);
        setup_cnt = 0;
        low_seg = 1;
      end else if (!sram_we_n) begin
        if (sram_addr != p_addr) begin
          check("R9 one-bit step", $countones(sram_addr ^ p_addr), 1);
          low_seg = 1;
        end else low_seg++;
      end
      if (!p_we && sram_we_n) begin
        check("R3 strobe length", low_seg, PL);
        check("R4 address at rise", sram_addr, p_addr);
        hold_cnt = 0;
      end
      if (sram_we_n && sram_data_oe) begin
        hold_cnt++;
        check("R5 ready low in hold", req_ready, 0);
        if (!p_we || p_doe) check("R4 address in hold", sram_addr, p_addr);
      end
      if (p_doe && sram_we_n && !sram_data_oe) begin
        check("R4 hold length", hold_cnt, H);
        check("R5 ready back in idle", req_ready, 1);
      end
      // write lands when strobe rises or address moves under it
      if (!p_we && (sram_we_n || sram_addr != p_addr)) mdl_mem[p_addr] = p_data;
      p_we = sram_we_n; p_doe = sram_data_oe; p_addr = sram_addr;
      p_data = sram_data; started = 1'b1;
    end
  end

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic st, input logic lst);
    req_valid = 1'b1; req_addr = a; req_data = d; req_stream = st; req_last = lst;
    @(negedge clk_i);
    while (!req_ready) @(negedge clk_i);
    @(posedge clk_i);
    #(CLK_PERIOD*0.25);
    req_valid = 1'b0;
    req_addr = AW'($urandom); req_data = DW'($urandom);
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      #(CLK_PERIOD*0.25);
    end
  endtask

  task automatic single(input logic [AW-1:0] a, input logic [DW-1:0] d);
    put(a, d, 1'b0, 1'($urandom));   // R8: last has no effect here
    exp_mem[a] = d;
  endtask

  task automatic burst(input logic [AW-1:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      logic [AW-1:0] b;
      d = DW'($urandom);
      b = base + AW'(i);
      put(base, d, 1'b1, i == n - 1);   // R11 last word closes the burst
      exp_mem[g_of(b)] = d;             // R9 Gray address
      if (i != n - 1 && ($urandom % 3) == 0) gap(1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2**AW; i++) begin
      exp_mem[i] = '0;
      mdl_mem[i] = '0;
    end
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD*0.25);
    rst_ni = 1'b1;
    check("R1 ready", req_ready, 1);
    check("R1 strobe", sram_we_n, 1);
    check("R1 drivers", sram_data_oe, 0);
    check("R1 read enable", sram_oe_n, 1);
    gap(2);

    single(8'h00, 16'hA5A5);
    single(8'hFF, 16'h5A5A);
    single(8'hFF, 16'h1234);            // overwrite, back to back
    burst(8'h10, 1);                    // R11 one-word burst
    burst(8'hFC, 7);                    // R9 wrap past top
    burst(8'h40, 12);
    for (int t = 0; t < 40; t++) begin
      if (($urandom % 4) == 0) burst(AW'($urandom), 2 + int'($urandom % 8));
      else single(AW'($urandom), DW'($urandom));
      if (($urandom % 2) == 0) gap(int'($urandom % 3));
    end
    gap(S + PL + H + 4);
    for (int i = 0; i < 2**AW; i++) check("R8/R9 memory contents", mdl_mem[i], exp_mem[i]);
    check("R1 idle at end", req_ready, 1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule